// File: doc/BRIEF.md
# PWM Channel Counter with One-Count Phase Nudging

This block is one pulse-width-modulation channel. A 16-bit counter advances by one step on each tick from an external clock divider. Two compare levels, A and B, are high while the count is below their compare values, and each can be inverted. The counter either counts up and wraps after a programmable top value (trailing-edge style), or counts up to the top value and back down to zero (phase-correct style).

Software can shift the running waveform by exactly one count in either direction, without stopping it. A retard request swallows the next divider tick. An advance request inserts an extra counter step on a system-clock cycle that carries no tick. An advance is only possible when the divider is slower than the system clock, so the block takes a flag from the divider that says so. Both request bits read back as 1 while pending and clear themselves once applied.

Writes to the top and compare values go to shadow registers. These are copied into the working set only at a period boundary, or at once while the channel is disabled, so reprogramming never produces a glitch.

Top module: `pwm_nudge_channel`

## Requirements
- R1: After reset the control readback is 0x00, the count is 0, no request is pending and both outputs are low. Control bits 5 and 4 always read 0.
- R2: Control bit 0 (address 0) enables the channel. While it is 0, ticks are ignored and the count holds its value.
- R3: With control bit 1 = 0, each step adds one to the count. A step taken at a count greater than or equal to the working top value (address 1) returns the count to 0.
- R4: With control bit 1 = 1, the count rises to the top value, then falls to 0, then rises again. A step taken at count 0 never takes the count above 1.
- R5: Before inversion, output A is high while count < compare A (address 2), and output B is high while count < compare B (address 3).
- R6: Writes to top, compare A and compare B take effect only at a period boundary: the wrap to 0 in trailing mode, or the turn at 0 in phase-correct mode. While the channel is disabled they take effect on the next cycle.
- R7: Writing 1 to control bit 6 sets a retard request that reads back as 1. The next divider tick while the channel is enabled is swallowed, and the bit then clears. Writing 0 to the bit does not cancel a pending request.
- R8: Writing 1 to control bit 7 sets an advance request that reads back as 1. On a cycle where the channel is enabled, the slow-divider flag is high and no tick arrives, one extra step is taken and the bit clears.
- R9: While the slow-divider flag is low, a pending advance stays pending and inserts no step.
- R10: While the channel is disabled, pending retard and advance requests stay pending.
- R11: Control bit 2 inverts output A and control bit 3 inverts output B.
- R12: When both requests are pending, the retard is taken on a tick cycle and the advance on a quiet cycle, independently. The net phase is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 top, 2 compare A, 3 compare B |
| regWdata | input | 16 | Write data; control uses bits 7:0 |
| divTick | input | 1 | Step enable from the clock divider |
| divSlow | input | 1 | High when the divider ratio is greater than one |
| outA | output | 1 | Compare output A after inversion |
| outB | output | 1 | Compare output B after inversion |
| ctrlRdata | output | 8 | Control register readback, including pending request bits |

## Verification
The retard and the advance can both be pending at once. They compete for the same counter, and the cycle type decides which one applies. The bench provokes this by setting both request bits while the slow flag is high and the tick is low. On the following quiet cycle only the advance may act: the count moves one ahead and the readback keeps only the retard bit. The next tick is then swallowed. The phase is judged afterwards, through where output B falls relative to compare B and where output A rises again after the wrap.

// File: rtl/pwm_nudge_pkg.sv
package pwm_nudge_pkg;

  // control register bit positions
  localparam int EN_BIT   = 0;
  localparam int PC_BIT   = 1;
  localparam int INVA_BIT = 2;
  localparam int INVB_BIT = 3;
  localparam int CTRL_W   = 8;

  // register addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_TOP  = 1;
  localparam int ADDR_CCA  = 2;

  // number of compare outputs
  localparam int CH_N = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic run;     // channel enabled
    logic step;    // advance counter this cycle
    logic phCorr;  // up/down counting
  } stepCtl_t;

endpackage

// File: rtl/pwm_nudge_ctrl.sv
module pwm_nudge_ctrl
  import pwm_nudge_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        wrLow,   // enable, mode, invert A, invert B
  input  logic [1:0]        wrReq,   // [0] retard, [1] advance
  input  logic              divTick,
  input  logic              divSlow,
  output stepCtl_t          stepCtl,
  output logic [CH_N-1:0]   invBits,
  output logic [CTRL_W-1:0] ctrlRdata
);

  logic enReg, pcReg, invAReg, invBReg;
  logic retPend, advPend;
  logic ctrlWr, applyRet, applyAdv;

  assign ctrlWr   = regWe && (regAddr == ADDR_W'(ADDR_CTRL));

  // retard swallows a tick; advance fills a quiet cycle
  assign applyRet = enReg && retPend && divTick;
  assign applyAdv = enReg && advPend && divSlow && !divTick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enReg   <= 1'b0;
      pcReg   <= 1'b0;
      invAReg <= 1'b0;
      invBReg <= 1'b0;
      retPend <= 1'b0;
      advPend <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enReg   <= wrLow[EN_BIT];
        pcReg   <= wrLow[PC_BIT];
        invAReg <= wrLow[INVA_BIT];
        invBReg <= wrLow[INVB_BIT];
      end
      retPend <= (retPend && !applyRet) || (ctrlWr && wrReq[0]);
      advPend <= (advPend && !applyAdv) || (ctrlWr && wrReq[1]);
    end
  end

  always_comb begin
    stepCtl.run    = enReg;
    stepCtl.phCorr = pcReg;
    stepCtl.step   = enReg && ((divTick && !retPend) || applyAdv);
  end

  assign invBits   = {invBReg, invAReg};
  assign ctrlRdata = {advPend, retPend, 2'b00, invBReg, invAReg, pcReg, enReg};

endmodule

// File: rtl/pwm_nudge_dp.sv
module pwm_nudge_dp
  import pwm_nudge_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  input  stepCtl_t          stepCtl,
  input  logic [CH_N-1:0]   invBits,
  output logic [CH_N-1:0]   outBits,
  output logic [CNT_W-1:0]  cntValue,
  output logic [CNT_W-1:0]  topValue
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, nextCnt, topLive, topAct;
  logic             down, nextDown, boundary, loadNow;

  // next-state of the counter
  always_comb begin
    nextCnt  = cnt;
    nextDown = down;
    boundary = 1'b0;
    if (stepCtl.step) begin
      if (!stepCtl.phCorr) begin
        nextDown = 1'b0;
        if (cnt >= topAct) begin
          nextCnt  = '0;
          boundary = 1'b1;
        end else begin
          nextCnt = cnt + ONE;
        end
      end else if (!down) begin
        if (cnt >= topAct) begin
          if (topAct == '0) begin
            nextCnt  = '0;
            boundary = 1'b1;
          end else begin
            nextCnt  = cnt - ONE;
            nextDown = 1'b1;
          end
        end else begin
          nextCnt = cnt + ONE;
        end
      end else begin
        if (cnt == '0) begin
          nextCnt  = (topAct == '0) ? '0 : ONE;
          nextDown = 1'b0;
          boundary = 1'b1;
        end else begin
          nextCnt = cnt - ONE;
        end
      end
    end
  end

  assign loadNow = !stepCtl.run || boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      down    <= 1'b0;
      topLive <= '0;
      topAct  <= '0;
    end else begin
      cnt  <= nextCnt;
      down <= nextDown;
      if (regWe && regAddr == ADDR_W'(ADDR_TOP)) topLive <= regWdata;
      if (loadNow) topAct <= topLive;
    end
  end

  // one shadowed compare per output
  for (genvar g = 0; g < CH_N; g++) begin : g_cmp
    logic [CNT_W-1:0] ccLive, ccAct;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ccLive <= '0;
        ccAct  <= '0;
      end else begin
        if (regWe && regAddr == ADDR_W'(ADDR_CCA + g)) ccLive <= regWdata;
        if (loadNow) ccAct <= ccLive;
      end
    end
    assign outBits[g] = (cnt < ccAct) ^ invBits[g];
  end

  assign cntValue = cnt;
  assign topValue = topAct;

endmodule

// File: rtl/pwm_nudge_channel.sv
module pwm_nudge_channel
  import pwm_nudge_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  input  logic              divTick,
  input  logic              divSlow,
  output logic              outA,
  output logic              outB,
  output logic [CTRL_W-1:0] ctrlRdata
);

  stepCtl_t         stepCtl;
  logic [CH_N-1:0]  invBits, outBits;
  logic [CNT_W-1:0] cntValue, topValue;

  pwm_nudge_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .wrLow    (regWdata[3:0]),
    .wrReq    (regWdata[7:6]),
    .divTick  (divTick),
    .divSlow  (divSlow),
    .stepCtl  (stepCtl),
    .invBits  (invBits),
    .ctrlRdata(ctrlRdata)
  );

  pwm_nudge_dp #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .regWe   (regWe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .stepCtl (stepCtl),
    .invBits (invBits),
    .outBits (outBits),
    .cntValue(cntValue),
    .topValue(topValue)
  );

  assign outA = outBits[0];
  assign outB = outBits[1];

endmodule

// File: rtl/pwm_nudge_chk.sv
module pwm_nudge_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              divTick,
  input logic              divSlow,
  input logic [7:0]        ctrlRdata,
  input logic [CNT_W-1:0]  cntValue,
  input logic [CNT_W-1:0]  topValue,
  input logic              step,
  input logic              phCorr
);

  logic ctrlWr;
  assign ctrlWr = regWe && (regAddr == '0);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrlRdata == 8'h00));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlRdata[0] |=> $stable(cntValue));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !phCorr && cntValue >= topValue) |=> (cntValue == '0));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phCorr && cntValue == '0) |=> (cntValue <= CNT_W'(1)));

  p_retard_swallow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlRdata[0] && ctrlRdata[6] && divTick && !ctrlWr)
      |=> ($stable(cntValue) && !ctrlRdata[6]));

  p_advance_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlRdata[0] && ctrlRdata[7] && divSlow && !divTick && !ctrlWr)
      |=> !ctrlRdata[7]);

  p_advance_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlRdata[7] && !divSlow && !ctrlWr) |=> ctrlRdata[7]);

  p_pend_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrlRdata[0] && ctrlRdata[6] && !ctrlWr) |=> ctrlRdata[6]);

endmodule

bind pwm_nudge_channel pwm_nudge_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .divTick  (divTick),
  .divSlow  (divSlow),
  .ctrlRdata(ctrlRdata),
  .cntValue (cntValue),
  .topValue (topValue),
  .step     (stepCtl.step),
  .phCorr   (stepCtl.phCorr)
);

// File: tb/test_pwm_nudge_channel.sv
`timescale 1ns/1ps
module test_pwm_nudge_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic        divTick = 1'b0;
  logic        divSlow = 1'b0;
  logic        outA, outB;
  logic [7:0]  ctrlRdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic       a;
    logic       b;
    logic [7:0] rd;
    bit         useRd;
  } expItem_t;

  expItem_t sbq[$];

  always #2 clk = ~clk;

  pwm_nudge_channel i_pwm_nudge_channel (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .divTick(divTick), .divSlow(divSlow),
    .outA(outA), .outB(outB), .ctrlRdata(ctrlRdata)
  );

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      expItem_t e;
      e = sbq.pop_front();
      checks++;
      if (outA !== e.a || outB !== e.b || (e.useRd && ctrlRdata !== e.rd)) begin
        errors++;
        $display("FAIL %s: A=%b B=%b rd=%h expected A=%b B=%b rd=%h",
                 e.req, outA, outB, ctrlRdata, e.a, e.b, e.rd);
      end
    end
  end

  task automatic push(string req, logic a, logic b, logic [7:0] rd, bit useRd);
    expItem_t e;
    e.req = req; e.a = a; e.b = b; e.rd = rd; e.useRd = useRd;
    sbq.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick(int n);
    divTick = 1'b1;
    repeat (n) @(posedge clk);
    #1 divTick = 1'b0;
  endtask

  task automatic wr(int a, int d);
    regWe = 1'b1; regAddr = 2'(a); regWdata = 16'(d);
    @(posedge clk);
    #1 regWe = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push("R1 reset", 0, 0, 8'h00, 1);
    idle(1);

    // load top 9, compare A 4, compare B 7 while disabled
    wr(1, 9); wr(2, 4); wr(3, 7); idle(1);
    push("R6 load while disabled", 1, 1, 8'h00, 1);

    // trailing-edge counting
    wr(0, 'h01);
    tick(3); push("R5 count3", 1, 1, 8'h01, 1);
    tick(1); push("R5 count4", 0, 1, 8'h01, 1);
    tick(3); push("R5 count7", 0, 0, 8'h01, 1);
    tick(2); push("R3 count9", 0, 0, 8'h01, 1);
    tick(1); push("R3 wrap0", 1, 1, 8'h01, 1);

    // disabled: hold at 3
    tick(3); wr(0, 'h00); tick(5);
    push("R2 hold", 1, 1, 8'h00, 1);

    // inversion
    wr(0, 'h0D); push("R11 invert", 0, 0, 8'h0D, 1);
    wr(0, 'h01); push("R11 plain", 1, 1, 8'h01, 1);

    // shadowed compare: count 3, new compare A = 2
    wr(2, 2); idle(2); push("R6 not yet", 1, 1, 8'h01, 1);
    tick(7); push("R6 at wrap", 1, 1, 8'h01, 1);
    tick(2); push("R6 applied", 0, 1, 8'h01, 1);

    // retard at count 1
    tick(9); push("R5 count1", 1, 1, 8'h01, 1);
    wr(0, 'h41); push("R7 pending", 1, 1, 8'h41, 1);
    idle(3); push("R7 still pending", 1, 1, 8'h41, 1);
    tick(1); push("R7 swallowed", 1, 1, 8'h01, 1);
    tick(1); push("R7 resumes", 0, 1, 8'h01, 1);

    // advance blocked at full rate, count 1
    tick(9);
    wr(0, 'h81); idle(3);
    push("R9 advance waits", 1, 1, 8'h81, 1);
    divSlow = 1'b1; idle(1);
    push("R8 advance applied", 0, 1, 8'h01, 1);

    // requests held while disabled, count 2
    wr(0, 'h40); tick(3);
    push("R10 held", 0, 1, 8'h40, 1);
    wr(0, 'h01); push("R10 kept on enable", 0, 1, 8'h41, 1);
    tick(5); push("R7 one tick lost", 0, 1, 8'h01, 1);

    // both requests together, count 6, slow divider
    wr(0, 'hC1); push("R12 both pending", 0, 1, 8'hC1, 1);
    idle(1); push("R12 advance on quiet cycle", 0, 0, 8'h41, 1);
    tick(1); push("R12 retard on tick", 0, 0, 8'h01, 1);
    tick(4); push("R12 net phase", 1, 1, 8'h01, 1);
    divSlow = 1'b0;

    // phase-correct counting from 0
    tick(9); push("R3 back at 0", 1, 1, 8'h01, 1);
    wr(0, 'h03);
    tick(9); push("R4 at top", 0, 0, 8'h03, 1);
    tick(1); push("R4 turn down", 0, 0, 8'h03, 1);
    tick(6); push("R4 count2 down", 0, 1, 8'h03, 1);
    tick(2); push("R4 bottom", 1, 1, 8'h03, 1);
    tick(1); push("R4 turn up", 1, 1, 8'h03, 1);
    tick(1); push("R4 rising", 0, 1, 8'h03, 1);

    idle(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule